// File: doc/BRIEF.md
# Non-Secure Privilege Control Register Block

This block is the non-secure-side register window of a peripheral protection scheme. Several peripheral protection controllers each guard a group of ports. The secure register window owns two bits per port: a bit that marks the port as non-secure, and a bit that sets the privilege level for secure accesses. This block owns the third bit, the privilege level for non-secure accesses, and software on the non-secure bus programs it through a 32-bit register slave of its own.

For every port the block drives a registered access-permission output. When the port is marked non-secure, the output follows the non-secure privilege bit held here. Otherwise it follows the secure privilege bit. The secure-side bits arrive as input vectors. The block also serves a read-only set of identification registers, and it returns zero for offsets that hold nothing.

There are ten controller slots. Slots 0 and 1 are the internal APB controllers, slots 2 to 5 are the APB expansion controllers, and slots 6 to 9 are the AHB expansion controllers. Each slot uses a fixed stride of `MAX_PORTS` bits in the flat port vectors.

Top module: `nsp_priv_ctrl`

## Requirements
- R1: While rst_ni is low and right after it is released, every stored non-secure privilege bit, ap_o and rdata_o are zero.
- R2: A word write (size_i=2) to a controller register stores wdata_i masked to that controller's port count. A read of the same address returns the stored value in rdata_o one clock after the request.
- R3: AHB expansion slots 6..9 sit at 0xA0/0xA4/0xA8/0xAC. Internal APB slots 0..1 sit at 0xB0/0xB4. APB expansion slots 2..5 sit at 0xC0/0xC4/0xC8/0xCC. Address bits [3:2] pick the slot within a group, and slot k drives ap_o[k*MAX_PORTS +: MAX_PORTS].
- R4: Each in-range ap_o bit equals the stored non-secure privilege bit when the matching sec_ns_i bit is 1, and the matching sec_sp_i bit when it is 0.
- R5: ap_o is registered. It changes on the first rising edge after a write or a secure input change, and not earlier.
- R6: A write with size_i of 0 (byte), 1 (halfword) or 3 leaves every stored bit unchanged.
- R7: A byte read returns the byte lane chosen by addr_i[1:0], zero-extended. A halfword read returns the 16 bits starting at that lane, zero-extended.
- R8: Identification words at 0xFD0..0xFFC read 0x04, 0x00, 0x00, 0x00, 0x53, 0xB8, ID_REV_SEL?0x2B:0x0B, 0x00, 0x0D, 0xF0, 0x05, 0xB1, in that address order.
- R9: Offset 0x90, the identification words and all unmapped offsets cannot be written. 0x90 and unmapped offsets read zero, and no access ever signals an error.
- R10: Bits at or above a controller's port count (3 for slot 0, 1 for slot 1, 16 for expansion slots by default) read zero and drive ap_o low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Access request, one per cycle |
| we_i | input | 1 | 1 write, 0 read |
| addr_i | input | 12 | Byte address within the window |
| size_i | input | 2 | 0 byte, 1 halfword, 2 word |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid the cycle after a read request |
| sec_ns_i | input | NUM_SLOTS*MAX_PORTS | Per-port non-secure marks from the secure side |
| sec_sp_i | input | NUM_SLOTS*MAX_PORTS | Per-port secure privilege bits |
| ap_o | output | NUM_SLOTS*MAX_PORTS | Per-port access-permission outputs |

## Verification
The permission assertions take for granted that the secure-side input vectors are stable and low during reset. They also assume that at most one access is requested per cycle. The bench drives every input at the falling edge, keeps the secure vectors at zero until reset is released, and issues one access per cycle. It mixes random word writes, narrow writes and reads over the mapped, reserved and identification offsets with random secure vectors and a set of directed boundary accesses.

// File: rtl/nsp_ctrl_pkg.sv
package nsp_ctrl_pkg;
  localparam int unsigned DATA_W       = 32;
  localparam int unsigned ADDR_W       = 12;
  localparam int unsigned WADDR_W      = ADDR_W - 2;
  localparam int unsigned NUM_INT_APB  = 2;
  localparam int unsigned NUM_EXP_APB  = 4;
  localparam int unsigned NUM_EXP_AHB  = 4;
  localparam int unsigned NUM_SLOTS    = NUM_INT_APB + NUM_EXP_APB + NUM_EXP_AHB;
  localparam int unsigned SLOT_W       = $clog2(NUM_SLOTS);
  localparam int unsigned EXP_APB_BASE = NUM_INT_APB;
  localparam int unsigned EXP_AHB_BASE = NUM_INT_APB + NUM_EXP_APB;
  localparam int unsigned NUM_ID       = 12;
  localparam logic [WADDR_W-1:0] ID_WBASE = 10'h3F4;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } acc_size_e;

  typedef struct packed {
    logic              hit;
    logic [SLOT_W-1:0] slot;
  } slot_sel_t;

  function automatic int unsigned slot_ports(input int unsigned s, input int unsigned apb0,
                                             input int unsigned apb1, input int unsigned exp);
    if (s == 0) return apb0;
    if (s == 1) return apb1;
    return exp;
  endfunction

  // word address groups: 0xA* ahb exp, 0xB0/0xB4 int apb, 0xC* apb exp
  function automatic slot_sel_t decode_slot(input logic [WADDR_W-1:0] waddr);
    slot_sel_t r;
    r.hit  = 1'b0;
    r.slot = '0;
    case (waddr[WADDR_W-1:2])
      8'h0A: begin
        r.hit  = 1'b1;
        r.slot = SLOT_W'(EXP_AHB_BASE) + SLOT_W'(waddr[1:0]);
      end
      8'h0B: begin
        if (!waddr[1]) begin
          r.hit  = 1'b1;
          r.slot = SLOT_W'(waddr[0]);
        end
      end
      8'h0C: begin
        r.hit  = 1'b1;
        r.slot = SLOT_W'(EXP_APB_BASE) + SLOT_W'(waddr[1:0]);
      end
      default: ;
    endcase
    return r;
  endfunction

  function automatic logic [7:0] id_byte(input logic [3:0] idx, input logic rev_b);
    case (idx)
      4'd0:    return 8'h04;
      4'd4:    return 8'h53;
      4'd5:    return 8'hB8;
      4'd6:    return rev_b ? 8'h2B : 8'h0B;
      4'd8:    return 8'h0D;
      4'd9:    return 8'hF0;
      4'd10:   return 8'h05;
      4'd11:   return 8'hB1;
      default: return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/nsp_regfile.sv
module nsp_regfile
  import nsp_ctrl_pkg::*;
#(
  parameter int unsigned APB0_PORTS = 3,
  parameter int unsigned APB1_PORTS = 1,
  parameter int unsigned EXP_PORTS  = 16,
  parameter int unsigned MAX_PORTS  = 16
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           wr_en_i,
  input  logic [SLOT_W-1:0]              wr_slot_i,
  input  logic [DATA_W-1:0]              wdata_i,
  output logic [NUM_SLOTS*MAX_PORTS-1:0] nsp_q_o,
  output logic [NUM_SLOTS*MAX_PORTS-1:0] nsp_d_o
);
  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    localparam int unsigned P = slot_ports(s, APB0_PORTS, APB1_PORTS, EXP_PORTS);
    localparam logic [MAX_PORTS-1:0] MASK =
      (P >= MAX_PORTS) ? {MAX_PORTS{1'b1}} : MAX_PORTS'((64'd1 << P) - 64'd1);
    logic [MAX_PORTS-1:0] q, d;

    always_comb begin
      d = q;
      if (wr_en_i && (wr_slot_i == SLOT_W'(s))) d = wdata_i[MAX_PORTS-1:0] & MASK;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q <= '0;
      else         q <= d;
    end

    assign nsp_q_o[s*MAX_PORTS +: MAX_PORTS] = q;
    assign nsp_d_o[s*MAX_PORTS +: MAX_PORTS] = d;
  end
endmodule

// File: rtl/nsp_ap_select.sv
module nsp_ap_select
  import nsp_ctrl_pkg::*;
#(
  parameter int unsigned APB0_PORTS = 3,
  parameter int unsigned APB1_PORTS = 1,
  parameter int unsigned EXP_PORTS  = 16,
  parameter int unsigned MAX_PORTS  = 16
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [NUM_SLOTS*MAX_PORTS-1:0] ns_i,
  input  logic [NUM_SLOTS*MAX_PORTS-1:0] sp_i,
  input  logic [NUM_SLOTS*MAX_PORTS-1:0] nsp_d_i,
  output logic [NUM_SLOTS*MAX_PORTS-1:0] ap_o
);
  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    localparam int unsigned P = slot_ports(s, APB0_PORTS, APB1_PORTS, EXP_PORTS);
    localparam logic [MAX_PORTS-1:0] MASK =
      (P >= MAX_PORTS) ? {MAX_PORTS{1'b1}} : MAX_PORTS'((64'd1 << P) - 64'd1);
    logic [MAX_PORTS-1:0] ns, sel_d, ap_q;

    assign ns    = ns_i[s*MAX_PORTS +: MAX_PORTS];
    // next-state nsp so a write shows on the first edge after it
    assign sel_d = MASK & ((ns & nsp_d_i[s*MAX_PORTS +: MAX_PORTS]) |
                           (~ns & sp_i[s*MAX_PORTS +: MAX_PORTS]));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ap_q <= '0;
      else         ap_q <= sel_d;
    end

    assign ap_o[s*MAX_PORTS +: MAX_PORTS] = ap_q;
  end
endmodule

// File: rtl/nsp_read_mux.sv
module nsp_read_mux
  import nsp_ctrl_pkg::*;
#(
  parameter int unsigned MAX_PORTS = 16,
  parameter bit          ID_REV_SEL = 1'b0
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           rd_en_i,
  input  logic [ADDR_W-1:0]              addr_i,
  input  logic [1:0]                     size_i,
  input  logic [NUM_SLOTS*MAX_PORTS-1:0] nsp_q_i,
  output logic [DATA_W-1:0]              rdata_o
);
  logic [WADDR_W-1:0] waddr;
  slot_sel_t          sel;
  logic [DATA_W-1:0]  word, shifted, lane;
  logic [WADDR_W-1:0] id_off;

  assign waddr  = addr_i[ADDR_W-1:2];
  assign sel    = decode_slot(waddr);
  assign id_off = waddr - ID_WBASE;

  always_comb begin
    word = '0;
    for (int s = 0; s < NUM_SLOTS; s++) begin
      if (sel.hit && (sel.slot == SLOT_W'(s))) word = DATA_W'(nsp_q_i[s*MAX_PORTS +: MAX_PORTS]);
    end
    if (waddr >= ID_WBASE) word = {24'd0, id_byte(id_off[3:0], ID_REV_SEL)};
  end

  assign shifted = word >> {addr_i[1:0], 3'b000};

  always_comb begin
    case (size_i)
      SZ_BYTE: lane = {24'd0, shifted[7:0]};
      SZ_HALF: lane = {16'd0, shifted[15:0]};
      default: lane = word;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_o <= '0;
    else if (rd_en_i) rdata_o <= lane;
  end
endmodule

// File: rtl/nsp_priv_ctrl.sv
module nsp_priv_ctrl
  import nsp_ctrl_pkg::*;
#(
  parameter int unsigned APB0_PORTS = 3,
  parameter int unsigned APB1_PORTS = 1,
  parameter int unsigned EXP_PORTS  = 16,
  parameter bit          ID_REV_SEL = 1'b0,
  localparam int unsigned MAX_A     = (APB0_PORTS > APB1_PORTS) ? APB0_PORTS : APB1_PORTS,
  localparam int unsigned MAX_PORTS = (MAX_A > EXP_PORTS) ? MAX_A : EXP_PORTS,
  localparam int unsigned VEC_W     = NUM_SLOTS * MAX_PORTS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        size_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [VEC_W-1:0]  sec_ns_i,
  input  logic [VEC_W-1:0]  sec_sp_i,
  output logic [VEC_W-1:0]  ap_o
);
  slot_sel_t        wr_sel;
  logic             wr_en, rd_en;
  logic [VEC_W-1:0] nsp_q, nsp_d;

  assign wr_sel = decode_slot(addr_i[ADDR_W-1:2]);
  // narrow writes dropped; reserved, id and unmapped words never decode
  assign wr_en  = req_i && we_i && (size_i == SZ_WORD) && wr_sel.hit;
  assign rd_en  = req_i && !we_i;

  nsp_regfile #(
    .APB0_PORTS(APB0_PORTS), .APB1_PORTS(APB1_PORTS),
    .EXP_PORTS (EXP_PORTS),  .MAX_PORTS (MAX_PORTS)
  ) i_regfile (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en),
    .wr_slot_i(wr_sel.slot),
    .wdata_i  (wdata_i),
    .nsp_q_o  (nsp_q),
    .nsp_d_o  (nsp_d)
  );

  nsp_ap_select #(
    .APB0_PORTS(APB0_PORTS), .APB1_PORTS(APB1_PORTS),
    .EXP_PORTS (EXP_PORTS),  .MAX_PORTS (MAX_PORTS)
  ) i_ap_select (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ns_i   (sec_ns_i),
    .sp_i   (sec_sp_i),
    .nsp_d_i(nsp_d),
    .ap_o   (ap_o)
  );

  nsp_read_mux #(
    .MAX_PORTS(MAX_PORTS), .ID_REV_SEL(ID_REV_SEL)
  ) i_read_mux (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rd_en_i(rd_en),
    .addr_i (addr_i),
    .size_i (size_i),
    .nsp_q_i(nsp_q),
    .rdata_o(rdata_o)
  );
endmodule

// File: rtl/nsp_priv_ctrl_chk.sv
module nsp_priv_ctrl_chk
  import nsp_ctrl_pkg::*;
#(
  parameter int unsigned APB0_PORTS = 3,
  parameter int unsigned APB1_PORTS = 1,
  parameter int unsigned EXP_PORTS  = 16,
  parameter int unsigned MAX_PORTS  = 16
) (
  input logic                           clk_i,
  input logic                           rst_ni,
  input logic                           req_i,
  input logic                           we_i,
  input logic [ADDR_W-1:0]              addr_i,
  input logic [1:0]                     size_i,
  input logic [DATA_W-1:0]              rdata_o,
  input logic [NUM_SLOTS*MAX_PORTS-1:0] sec_ns_i,
  input logic [NUM_SLOTS*MAX_PORTS-1:0] sec_sp_i,
  input logic [NUM_SLOTS*MAX_PORTS-1:0] nsp_q_i,
  input logic [NUM_SLOTS*MAX_PORTS-1:0] ap_o
);
  logic [NUM_SLOTS*MAX_PORTS-1:0] port_mask;
  logic                           past_ok;

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_mask
    localparam int unsigned P = slot_ports(s, APB0_PORTS, APB1_PORTS, EXP_PORTS);
    for (genvar p = 0; p < MAX_PORTS; p++) begin : g_bit
      assign port_mask[s*MAX_PORTS+p] = (p < P);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  p_ap_select_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && !$past(req_i && we_i)) |->
      ap_o == (port_mask & (($past(sec_ns_i) & $past(nsp_q_i)) |
                            (~$past(sec_ns_i) & $past(sec_sp_i)))));

  p_no_extra_bits_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((nsp_q_i & ~port_mask) == '0) && ((ap_o & ~port_mask) == '0));

  p_narrow_wr_ignored_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && (size_i != SZ_WORD)) |=> $stable(nsp_q_i));

  p_ro_wr_ignored_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && (addr_i[ADDR_W-1:2] >= ID_WBASE || addr_i[ADDR_W-1:2] == 10'h024))
      |=> $stable(nsp_q_i));

  p_byte_rd_zext_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && (size_i == SZ_BYTE)) |=> (rdata_o[31:8] == '0));

  p_half_rd_zext_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && (size_i == SZ_HALF)) |=> (rdata_o[31:16] == '0));

  p_id_fifth_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && (size_i == SZ_WORD) && (addr_i == 12'hFE0)) |=> (rdata_o == 32'h53));

  p_reserved_rd_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && (addr_i[ADDR_W-1:2] == 10'h024)) |=> (rdata_o == '0));
endmodule

bind nsp_priv_ctrl nsp_priv_ctrl_chk #(
  .APB0_PORTS(APB0_PORTS), .APB1_PORTS(APB1_PORTS),
  .EXP_PORTS (EXP_PORTS),  .MAX_PORTS (MAX_PORTS)
) i_nsp_priv_ctrl_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .req_i   (req_i),
  .we_i    (we_i),
  .addr_i  (addr_i),
  .size_i  (size_i),
  .rdata_o (rdata_o),
  .sec_ns_i(sec_ns_i),
  .sec_sp_i(sec_sp_i),
  .nsp_q_i (nsp_q),
  .ap_o    (ap_o)
);

// File: tb/test_nsp_priv_ctrl.sv
`timescale 1ns/1ps
module test_nsp_priv_ctrl;
  localparam int NS = 10;
  localparam int MP = 16;
  localparam int VW = NS * MP;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          req_i = 1'b0;
  logic          we_i = 1'b0;
  logic [11:0]   addr_i = '0;
  logic [1:0]    size_i = 2'd2;
  logic [31:0]   wdata_i = '0;
  logic [31:0]   rdata_o;
  logic [VW-1:0] sec_ns_i = '0;
  logic [VW-1:0] sec_sp_i = '0;
  logic [VW-1:0] ap_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  logic [15:0] model [NS];

  always #2 clk_i = ~clk_i;

  nsp_priv_ctrl i_nsp_priv_ctrl (.*);

  function automatic int ports_of(int s);
    return (s == 0) ? 3 : (s == 1) ? 1 : 16;
  endfunction

  function automatic logic [15:0] mask_of(int s);
    return 16'((32'd1 << ports_of(s)) - 1);
  endfunction

  // R3 address map
  function automatic int slot_of(logic [11:0] a);
    if (a[11:4] == 8'h0A) return 6 + int'(a[3:2]);
    if (a[11:4] == 8'h0B && !a[3]) return int'(a[2]);
    if (a[11:4] == 8'h0C) return 2 + int'(a[3:2]);
    return -1;
  endfunction

  function automatic logic [7:0] id_exp(int i);
    logic [7:0] t [12] = '{8'h04, 8'h00, 8'h00, 8'h00, 8'h53, 8'hB8,
                           8'h0B, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
    return t[i];
  endfunction

  function automatic logic [31:0] read_exp(logic [11:0] a, logic [1:0] sz);
    logic [31:0] w;
    int s;
    w = '0;
    s = slot_of(a);
    if (s >= 0) w = {16'd0, model[s]};
    else if (a >= 12'hFD0) w = {24'd0, id_exp(int'((a - 12'hFD0) >> 2))};
    if (sz == 2'd0) return (w >> (8 * a[1:0])) & 32'hFF;
    if (sz == 2'd1) return (w >> (8 * a[1:0])) & 32'hFFFF;
    return w;
  endfunction

  function automatic logic [VW-1:0] ap_exp();
    logic [VW-1:0] v;
    v = '0;
    for (int s = 0; s < NS; s++)
      for (int p = 0; p < ports_of(s); p++)
        v[s*MP+p] = sec_ns_i[s*MP+p] ? model[s][p] : sec_sp_i[s*MP+p];
    return v;
  endfunction

  task automatic chk(bit ok, string req, logic [VW-1:0] act, logic [VW-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one access per cycle; inputs driven at negedge, outputs checked at next negedge
  task automatic step(bit rq, bit we, logic [11:0] a, logic [1:0] sz, logic [31:0] wd,
                      logic [VW-1:0] ns, logic [VW-1:0] sp, string req);
    logic [VW-1:0] ap_before;
    logic [31:0]   rexp;
    int            s;
    ap_before = ap_o;
    req_i = rq; we_i = we; addr_i = a; size_i = sz; wdata_i = wd;
    sec_ns_i = ns; sec_sp_i = sp;
    rexp = read_exp(a, sz);
    #1;
    chk(ap_o == ap_before, "R5 no early change", ap_o, ap_before);
    @(posedge clk_i);
    s = slot_of(a);
    if (rq && we && sz == 2'd2 && s >= 0) model[s] = wd[15:0] & mask_of(s);
    @(negedge clk_i);
    chk(ap_o == ap_exp(), "R4/R5 ap", ap_o, ap_exp());
    if (rq && !we) chk(rdata_o == rexp, req, VW'(rdata_o), VW'(rexp));
    req_i = 1'b0;
  endtask

  task automatic wr(logic [11:0] a, logic [1:0] sz, logic [31:0] d, string req);
    step(1'b1, 1'b1, a, sz, d, sec_ns_i, sec_sp_i, req);
  endtask

  task automatic rd(logic [11:0] a, logic [1:0] sz, string req);
    step(1'b1, 1'b0, a, sz, 32'd0, sec_ns_i, sec_sp_i, req);
  endtask

  function automatic logic [VW-1:0] rand_vec();
    logic [VW-1:0] v;
    for (int i = 0; i < VW; i += 32) v[i +: 32] = $urandom();
    return v;
  endfunction

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [11:0] pool [20] = '{12'h0A0, 12'h0A4, 12'h0A8, 12'h0AC, 12'h0B0, 12'h0B4,
                               12'h0B8, 12'h0C0, 12'h0C4, 12'h0C8, 12'h0CC, 12'h090,
                               12'h0D0, 12'hFD0, 12'hFE0, 12'hFE8, 12'hFFC, 12'h000,
                               12'h0BC, 12'h0A2};
    void'($urandom(32'h5EED));
    for (int s = 0; s < NS; s++) model[s] = '0;
    repeat (3) @(negedge clk_i);
    chk(ap_o == '0, "R1 ap in reset", ap_o, '0);
    chk(rdata_o == '0, "R1 rdata in reset", VW'(rdata_o), '0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(ap_o == '0, "R1 ap after reset", ap_o, '0);
    for (int s = 0; s < 11; s++) rd(pool[s], 2'd2, "R1 reg zero after reset");

    wr(12'h0B0, 2'd2, 32'hFFFF_FFFF, "R10");
    rd(12'h0B0, 2'd2, "R10 slot0 masked to 3 ports");
    wr(12'h0B4, 2'd2, 32'hFFFF_FFFE, "R10");
    rd(12'h0B4, 2'd2, "R10 slot1 masked to 1 port");
    wr(12'h0A4, 2'd2, 32'hABCD_1234, "R2");
    rd(12'h0A4, 2'd2, "R2 ahb exp slot 7 readback");
    rd(12'h0A0, 2'd2, "R3 neighbour slot 6 untouched");
    wr(12'h0C8, 2'd2, 32'h0000_5678, "R2");
    rd(12'h0C9, 2'd0, "R7 byte lane 1");
    rd(12'h0C8, 2'd1, "R7 half lane 0");
    rd(12'h0CA, 2'd1, "R7 half lane 2");
    wr(12'h0C8, 2'd0, 32'h0000_0000, "R6");
    wr(12'h0C8, 2'd1, 32'h0000_0000, "R6");
    rd(12'h0C8, 2'd2, "R6 narrow writes ignored");
    wr(12'h090, 2'd2, 32'hFFFF_FFFF, "R9");
    rd(12'h090, 2'd2, "R9 reserved reads zero");
    wr(12'hFE0, 2'd2, 32'h0000_0000, "R9");
    for (int i = 0; i < 12; i++) rd(12'hFD0 + 12'(4 * i), 2'd2, "R8 id word");
    rd(12'hFE0, 2'd0, "R8 id byte read");
    rd(12'h444, 2'd2, "R9 unmapped reads zero");
    step(1'b0, 1'b0, 12'h0, 2'd2, 32'd0, '1, '0, "R4 all non-secure");
    step(1'b0, 1'b0, 12'h0, 2'd2, 32'd0, '0, '1, "R4 all secure");
    wr(12'h0C0, 2'd2, 32'h0000_00FF, "R5 write while ns mixed");

    for (int n = 0; n < 3000; n++) begin
      logic [11:0] a;
      logic [1:0]  sz;
      int k;
      k = int'($urandom_range(0, 19));
      a = ($urandom_range(0, 3) == 0) ? 12'($urandom()) : pool[k];
      sz = ($urandom_range(0, 3) == 0) ? 2'($urandom()) : 2'd2;
      if ($urandom_range(0, 3) == 0) step(1'b0, 1'b0, a, sz, 32'd0, rand_vec(), rand_vec(), "R4");
      else step(1'b1, 1'($urandom()), a, sz, $urandom(), rand_vec(), rand_vec(), "R2/R3/R7 random read");
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule